// File: doc/BRIEF.md
# Shared-Cache Performance Counter Bank

This block counts events for a shared cache. It holds a parameterised number of 32-bit event counters and one 64-bit free-running cycle counter. Each event counter advances on its own single-cycle increment strobe. The cycle counter advances on every clock while it is enabled. Software controls the bank through three 32-bit masks: counter enable, interrupt enable and overflow status. Each mask has a separate set address and a separate clear address. In all three masks, event counter `i` owns bit `i` and the cycle counter owns bit 31. Any counter can be loaded with a start value, for example half of its range, so that it overflows after a chosen number of events.

The host never addresses a register directly. It first writes a 12-bit register number to a select register. A later write or read to the data register then acts on the register that was selected. A small host-port state machine has two states. In `ST_IDLE` it accepts accesses. A data or select read moves it to `ST_RESP` (transition *read accepted*). There it presents the read data for one cycle with `host_rvalid` high, then returns to `ST_IDLE` (transition *response delivered*). Accesses are ignored while `host_ready` is low. One level-sensitive interrupt output reports any overflow whose interrupt is enabled.

Top module: `cpmu_bank`

## Requirements
- R1: After reset, all counters, all three masks and the global enable are zero, and `irq` is low.
- R2: A write with `host_sel`=0 latches the register number from `host_wdata[11:0]`. A read with `host_sel`=1 returns the selected register, and a read with `host_sel`=0 returns the latched register number. The data appears on `host_rdata` with `host_rvalid` high in the cycle after the read is accepted. `host_ready` is low during that response cycle.
- R3: The control register is number 0x400. Bit 0 is the global enable and can be read and written. Bits 15:11 always read back the number of event counters, and writes to them have no effect. A write whose bits 2:1 are both 1 (for example 0x6) sets every counter to zero.
- R4: The enable masks are at 0x404 (set) and 0x403 (clear). The interrupt-enable masks are at 0x406 (set) and 0x405 (clear). Reading either address of a pair returns that mask. Only bits written as 1 change, and bits with no counter behind them always read 0.
- R5: Event counter `i` increments on a cycle where its strobe is high only if the global enable and enable bit `i` are both set.
- R6: The 64-bit cycle counter at 0x40A increments once per clock while the global enable and enable bit 31 are both set, and carries across its 32-bit halves.
- R7: When a counter wraps from all ones to zero, its overflow bit is set in the same edge.
- R8: Reading 0x408 or 0x407 returns the overflow status. Writing a mask to 0x407 clears the bits written as 1, and writing to 0x408 sets them. A wrap and a clear of the same bit in the same cycle leave the bit set.
- R9: The value of event counter `i` is at 0x421 + 0x10·i, and it and the cycle counter can be written. A host write to a counter takes priority over an increment in the same cycle.
- R10: `irq` is high exactly while some overflow bit is set together with its interrupt-enable bit.
- R11: Register numbers with no register behind them read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | 0 = select register, 1 = data register |
| host_wr | input | 1 | Write request |
| host_rd | input | 1 | Read request |
| host_wdata | input | 64 | Write data |
| host_ready | output | 1 | High when an access can be accepted |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 64 | Read data |
| evt_strobe | input | NUM_EVT | Per-counter increment strobes |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench targets the following cases:
- Same-cycle collisions:
  - A host preload and a strobe in the same cycle. A design that gave the increment priority would read back the preload value plus one.
  - A wrap and an overflow clear in the same cycle. A design that let the clear win would lose the overflow silently.
- Counter edges:
  - The 32-bit carry inside the cycle counter. A counter split wrongly would stop at the low half.
  - Event wrap exactly at all ones, which must raise `irq` only while the interrupt enable bit is set.
- Mask writes:
  - Set and clear writes with zero bits. A design that treated them as full writes would wipe unrelated enables.
  - The read-only counter-count field, which a plain register would overwrite.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] A_CTRL     = 12'h400;
    localparam logic [REG_AW-1:0] A_EN_CLR   = 12'h403;
    localparam logic [REG_AW-1:0] A_EN_SET   = 12'h404;
    localparam logic [REG_AW-1:0] A_IE_CLR   = 12'h405;
    localparam logic [REG_AW-1:0] A_IE_SET   = 12'h406;
    localparam logic [REG_AW-1:0] A_OV_CLR   = 12'h407;
    localparam logic [REG_AW-1:0] A_OV_SET   = 12'h408;
    localparam logic [REG_AW-1:0] A_CYC      = 12'h40A;
    localparam logic [REG_AW-1:0] A_EVT_BASE = 12'h420;

    localparam int EVT_STRIDE    = 16;
    localparam int EVT_VAL_OFS   = 1;
    localparam int MASK_W        = 32;
    localparam int CYC_BIT       = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1
    } host_state_e;

    // decoded data-register write strobes
    typedef struct packed {
        logic ctrl;
        logic en_clr;
        logic en_set;
        logic ie_clr;
        logic ie_set;
        logic ov_clr;
        logic ov_set;
        logic cyc;
    } reg_wr_t;

    function automatic logic [REG_AW-1:0] evt_val_addr(input int idx);
        return A_EVT_BASE + REG_AW'(idx * EVT_STRIDE + EVT_VAL_OFS);
    endfunction

endpackage

// File: rtl/cpmu_counter.sv
module cpmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // a wrap only counts when the increment really lands
    assign wrap = inc && !load && !clr_all && (&cnt_q);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load && !clr_all) |=> $stable(cnt_q)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !clr_all) |=> (cnt_q == $past(cnt_q) + W'(1))); // R6

    AST_CNT_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load && !clr_all) |=> (cnt_q == $past(load_val))); // R9

endmodule

// File: rtl/cpmu_masks.sv
module cpmu_masks
    import cpmu_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              ov_set,
    input  logic              ov_clr,
    input  logic [MASK_W-1:0] wdata,
    input  logic [MASK_W-1:0] wrap_vec,
    output logic [MASK_W-1:0] en_q,
    output logic [MASK_W-1:0] ie_q,
    output logic [MASK_W-1:0] ov_q
);

    localparam logic [MASK_W-1:0] PRESENT =
        ((MASK_W'(1) << NUM_EVT) - MASK_W'(1)) | (MASK_W'(1) << CYC_BIT);

    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        if (PRESENT[b]) begin : g_live
            logic en_b, ie_b, ov_b;
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_b <= 1'b0;
                    ie_b <= 1'b0;
                    ov_b <= 1'b0;
                end else begin
                    if (en_set && wdata[b])      en_b <= 1'b1;
                    else if (en_clr && wdata[b]) en_b <= 1'b0;
                    if (ie_set && wdata[b])      ie_b <= 1'b1;
                    else if (ie_clr && wdata[b]) ie_b <= 1'b0;
                    // a wrap beats a clear of the same bit
                    if (wrap_vec[b] || (ov_set && wdata[b])) ov_b <= 1'b1;
                    else if (ov_clr && wdata[b])             ov_b <= 1'b0;
                end
            end
            assign en_q[b] = en_b;
            assign ie_q[b] = ie_b;
            assign ov_q[b] = ov_b;
        end else begin : g_absent
            assign en_q[b] = 1'b0;
            assign ie_q[b] = 1'b0;
            assign ov_q[b] = 1'b0;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ov_clr |=> ((ov_q & $past(ov_q)) == $past(ov_q))); // R8

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (|(wrap_vec & PRESENT)) |=>
        ((ov_q & $past(wrap_vec & PRESENT)) == $past(wrap_vec & PRESENT))); // R7

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        en_set |=> ((en_q & $past(wdata & PRESENT)) == $past(wdata & PRESENT))); // R4

endmodule

// File: rtl/cpmu_host_port.sv
module cpmu_host_port
    import cpmu_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int EVT_W   = 32,
    parameter int CYC_W   = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_sel,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [REG_AW-1:0]        sel_wdata,
    input  logic [MASK_W-1:0]        ctrl_view,
    input  logic [MASK_W-1:0]        en_view,
    input  logic [MASK_W-1:0]        ie_view,
    input  logic [MASK_W-1:0]        ov_view,
    input  logic [CYC_W-1:0]         cyc_view,
    input  logic [NUM_EVT*EVT_W-1:0] evt_view,
    output logic                     host_ready,
    output logic                     host_rvalid,
    output logic [CYC_W-1:0]         host_rdata,
    output reg_wr_t                  wr_o,
    output logic [NUM_EVT-1:0]       evt_wr_o
);

    host_state_e       state_q, state_d;
    logic [REG_AW-1:0] sel_q;
    logic [CYC_W-1:0]  rdata_q;
    logic [CYC_W-1:0]  reg_value;
    logic              acc_ok, sel_wr, data_wr, rd_take;

    assign acc_ok  = (state_q == ST_IDLE);
    assign sel_wr  = acc_ok && host_wr && !host_sel;
    assign data_wr = acc_ok && host_wr && host_sel;
    assign rd_take = acc_ok && host_rd && !host_wr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: read accepted, response delivered
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_take) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // select latch and read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (sel_wr)  sel_q   <= sel_wdata;
            if (rd_take) rdata_q <= host_sel ? reg_value : CYC_W'(sel_q);
        end
    end

    // read multiplexer over the selected register number
    always_comb begin
        reg_value = '0;
        case (sel_q)
            A_CTRL:             reg_value = CYC_W'(ctrl_view);
            A_EN_CLR, A_EN_SET: reg_value = CYC_W'(en_view);
            A_IE_CLR, A_IE_SET: reg_value = CYC_W'(ie_view);
            A_OV_CLR, A_OV_SET: reg_value = CYC_W'(ov_view);
            A_CYC:              reg_value = cyc_view;
            default:            reg_value = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_q == evt_val_addr(i)) reg_value = CYC_W'(evt_view[i*EVT_W +: EVT_W]);
        end
    end

    // write decode
    always_comb begin
        wr_o     = '0;
        evt_wr_o = '0;
        if (data_wr) begin
            case (sel_q)
                A_CTRL:   wr_o.ctrl   = 1'b1;
                A_EN_CLR: wr_o.en_clr = 1'b1;
                A_EN_SET: wr_o.en_set = 1'b1;
                A_IE_CLR: wr_o.ie_clr = 1'b1;
                A_IE_SET: wr_o.ie_set = 1'b1;
                A_OV_CLR: wr_o.ov_clr = 1'b1;
                A_OV_SET: wr_o.ov_set = 1'b1;
                A_CYC:    wr_o.cyc    = 1'b1;
                default:  ;
            endcase
            for (int i = 0; i < NUM_EVT; i++) begin
                evt_wr_o[i] = (sel_q == evt_val_addr(i));
            end
        end
    end

    // outputs
    always_comb begin
        host_ready  = (state_q == ST_IDLE);
        host_rvalid = (state_q == ST_RESP);
        host_rdata  = (state_q == ST_RESP) ? rdata_q : '0;
    end

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> (host_rvalid && !host_ready)); // R2

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid); // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(sel_q)); // R2

endmodule

// File: rtl/cpmu_bank.sv
module cpmu_bank
    import cpmu_pkg::*;
#(
    parameter int NUM_EVT = 4,   // 1..31
    parameter int EVT_W   = 32,
    parameter int CYC_W   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [CYC_W-1:0]   host_wdata,
    output logic               host_ready,
    output logic               host_rvalid,
    output logic [CYC_W-1:0]   host_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);

    localparam int CNT_FIELD_W = 5;

    reg_wr_t                  wr;
    logic [NUM_EVT-1:0]       evt_wr;
    logic                     gen_en_q;
    logic                     clear_all;
    logic [MASK_W-1:0]        ctrl_view, en_q, ie_q, ov_q, wrap_vec;
    logic [NUM_EVT*EVT_W-1:0] evt_flat;
    logic [NUM_EVT-1:0]       evt_wrap;
    logic [CYC_W-1:0]         cyc_q;
    logic                     cyc_wrap;

    // control register
    assign clear_all = wr.ctrl && (host_wdata[2:1] == 2'b11);

    always_ff @(posedge clk) begin
        if (rst)          gen_en_q <= 1'b0;
        else if (wr.ctrl) gen_en_q <= host_wdata[0];
    end

    assign ctrl_view = {16'b0, CNT_FIELD_W'(NUM_EVT), 10'b0, gen_en_q};

    cpmu_host_port #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W), .CYC_W(CYC_W)) u_port (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .sel_wdata  (host_wdata[REG_AW-1:0]),
        .ctrl_view  (ctrl_view),
        .en_view    (en_q),
        .ie_view    (ie_q),
        .ov_view    (ov_q),
        .cyc_view   (cyc_q),
        .evt_view   (evt_flat),
        .host_ready (host_ready),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .wr_o       (wr),
        .evt_wr_o   (evt_wr)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic inc_i;
        assign inc_i = gen_en_q && en_q[i] && evt_strobe[i];
        cpmu_counter #(.W(EVT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr_all (clear_all),
            .inc     (inc_i),
            .load    (evt_wr[i]),
            .load_val(host_wdata[EVT_W-1:0]),
            .cnt_q   (evt_flat[i*EVT_W +: EVT_W]),
            .wrap    (evt_wrap[i])
        );
    end

    cpmu_counter #(.W(CYC_W)) u_cyc (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clear_all),
        .inc     (gen_en_q && en_q[CYC_BIT]),
        .load    (wr.cyc),
        .load_val(host_wdata),
        .cnt_q   (cyc_q),
        .wrap    (cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        for (int i = 0; i < NUM_EVT; i++) wrap_vec[i] = evt_wrap[i];
        wrap_vec[CYC_BIT] = cyc_wrap;
    end

    cpmu_masks #(.NUM_EVT(NUM_EVT)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .en_set  (wr.en_set),
        .en_clr  (wr.en_clr),
        .ie_set  (wr.ie_set),
        .ie_clr  (wr.ie_clr),
        .ov_set  (wr.ov_set),
        .ov_clr  (wr.ov_clr),
        .wdata   (host_wdata[MASK_W-1:0]),
        .wrap_vec(wrap_vec),
        .en_q    (en_q),
        .ie_q    (ie_q),
        .ov_q    (ov_q)
    );

    assign irq = |(ov_q & ie_q);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ov_q == '0) |-> !irq); // R10

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        (!gen_en_q && !wr.cyc && !clear_all) |=> $stable(cyc_q)); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (cyc_q == '0)); // R3

endmodule

// File: tb/cpmu_bank_bench.sv
module cpmu_bank_bench;

    localparam int NUM_EVT = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [63:0]        host_wdata = '0;
    logic               host_ready, host_rvalid, irq;
    logic [63:0]        host_rdata;
    logic [NUM_EVT-1:0] evt_strobe = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    cpmu_bank #(.NUM_EVT(NUM_EVT)) u_cpmu_bank (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .evt_strobe(evt_strobe), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
                check("R2 ready low in response", {63'd0, host_ready}, 64'd0);
            end
        end
    end

    task automatic sel_reg(input logic [11:0] a);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b1; host_wdata = {52'd0, a};
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [63:0] v);
        sel_reg(a);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, input logic [63:0] exp, input string tag);
        sel_reg(a);
        exp_q.push_back(exp); tag_q.push_back(tag);
        host_sel = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt_strobe = m;
            @(negedge clk); evt_strobe = '0;
        end
    endtask

    // global enable held for k+3 clock edges
    task automatic run_cycles(input int k);
        wr_reg(12'h400, 64'd1);
        repeat (k) @(negedge clk);
        wr_reg(12'h400, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq after reset", {63'd0, irq}, 64'd0);
        rd_reg(12'h400, 64'h2000, "R1 ctrl reset");
        rd_reg(12'h404, 64'h0, "R1 enable reset");
        rd_reg(12'h408, 64'h0, "R1 overflow reset");
        rd_reg(12'h40A, 64'h0, "R1 cycle reset");
        rd_reg(12'h451, 64'h0, "R1 evt3 reset");
        // R2 select readback
        sel_reg(12'h421);
        exp_q.push_back(64'h421); tag_q.push_back("R2 select readback");
        host_sel = 1'b0; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        // R4 set/clear masks
        wr_reg(12'h404, 64'hFFFF_FFFF);
        rd_reg(12'h404, 64'h8000_000F, "R4 set all present");
        wr_reg(12'h403, 64'h2);
        rd_reg(12'h403, 64'h8000_000D, "R4 clear one bit");
        wr_reg(12'h404, 64'h0);
        rd_reg(12'h404, 64'h8000_000D, "R4 zero set no effect");
        wr_reg(12'h403, 64'hFFFF_FFFF);
        rd_reg(12'h404, 64'h0, "R4 clear all");
        wr_reg(12'h406, 64'h8000_0004);
        rd_reg(12'h405, 64'h8000_0004, "R4 irq enable set");
        wr_reg(12'h405, 64'hFFFF_FFFF);
        // R5 gating
        wr_reg(12'h404, 64'h5);
        pulse(4'hF, 3);
        rd_reg(12'h421, 64'd0, "R5 global enable off");
        wr_reg(12'h400, 64'd1);
        pulse(4'hF, 5);
        rd_reg(12'h421, 64'd5, "R5 evt0 counts");
        rd_reg(12'h431, 64'd0, "R5 evt1 disabled");
        rd_reg(12'h441, 64'd5, "R5 evt2 counts");
        rd_reg(12'h451, 64'd0, "R5 evt3 disabled");
        rd_reg(12'h40A, 64'd0, "R6 cycle disabled");
        // R9 write beats increment
        sel_reg(12'h421);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = 64'd50; evt_strobe = 4'h1;
        @(negedge clk); host_wr = 1'b0; evt_strobe = '0;
        rd_reg(12'h421, 64'd50, "R9 write priority");
        // R3 control
        wr_reg(12'h400, 64'hF801);
        rd_reg(12'h400, 64'h2001, "R3 count field read-only");
        wr_reg(12'h400, 64'h6);
        rd_reg(12'h421, 64'd0, "R3 reset all evt0");
        rd_reg(12'h441, 64'd0, "R3 reset all evt2");
        rd_reg(12'h400, 64'h2000, "R3 enable cleared");
        // R6 cycle counter
        wr_reg(12'h40A, 64'd100);
        rd_reg(12'h40A, 64'd100, "R9 cycle preload");
        wr_reg(12'h404, 64'h8000_0000);
        run_cycles(10);
        rd_reg(12'h40A, 64'd113, "R6 cycle count");
        wr_reg(12'h40A, 64'h0000_0000_FFFF_FFFF);
        run_cycles(0);
        rd_reg(12'h40A, 64'h0000_0001_0000_0002, "R6 carry");
        wr_reg(12'h40A, 64'hFFFF_FFFF_FFFF_FFFF);
        run_cycles(0);
        rd_reg(12'h40A, 64'd2, "R7 cycle wrap");
        rd_reg(12'h408, 64'h8000_0000, "R7 cycle overflow bit");
        check("R10 masked overflow", {63'd0, irq}, 64'd0);
        wr_reg(12'h407, 64'h8000_0000);
        wr_reg(12'h403, 64'h8000_0000);
        wr_reg(12'h40A, 64'h8000_0000_0000_0000);
        rd_reg(12'h40A, 64'h8000_0000_0000_0000, "R9 half-range preload");
        // R7 event wrap and R10 irq
        wr_reg(12'h431, 64'hFFFF_FFFE);
        wr_reg(12'h404, 64'h2);
        wr_reg(12'h406, 64'h2);
        wr_reg(12'h400, 64'd1);
        pulse(4'h2, 1);
        check("R10 no irq before wrap", {63'd0, irq}, 64'd0);
        rd_reg(12'h431, 64'hFFFF_FFFF, "R7 at all ones");
        pulse(4'h2, 1);
        check("R10 irq on wrap", {63'd0, irq}, 64'd1);
        rd_reg(12'h431, 64'd0, "R7 wrapped to zero");
        rd_reg(12'h408, 64'h2, "R7 overflow bit");
        wr_reg(12'h405, 64'h2);
        check("R10 irq masked", {63'd0, irq}, 64'd0);
        wr_reg(12'h406, 64'h2);
        check("R10 irq unmasked", {63'd0, irq}, 64'd1);
        // R8 overflow status
        wr_reg(12'h407, 64'h0);
        rd_reg(12'h408, 64'h2, "R8 zero clear no effect");
        wr_reg(12'h407, 64'h2);
        check("R10 irq after clear", {63'd0, irq}, 64'd0);
        rd_reg(12'h407, 64'h0, "R8 cleared");
        wr_reg(12'h408, 64'h1);
        rd_reg(12'h408, 64'h1, "R8 software set");
        wr_reg(12'h407, 64'h1);
        wr_reg(12'h431, 64'hFFFF_FFFF);
        sel_reg(12'h407);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = 64'h2; evt_strobe = 4'h2;
        @(negedge clk); host_wr = 1'b0; evt_strobe = '0;
        rd_reg(12'h408, 64'h2, "R8 wrap beats clear");
        rd_reg(12'h431, 64'd0, "R7 wrap during clear");
        check("R10 irq after collision", {63'd0, irq}, 64'd1);
        // R11 unmapped and R4 absent bits
        wr_reg(12'h408, 64'h7FFF_FFF0);
        rd_reg(12'h408, 64'h2, "R4 absent overflow bits");
        wr_reg(12'h401, 64'hFFFF);
        rd_reg(12'h401, 64'h0, "R11 unmapped read");
        rd_reg(12'h404, 64'h7, "R11 enable untouched");
        wr_reg(12'h420, 64'h1234);
        rd_reg(12'h420, 64'h0, "R11 block offset zero");
        rd_reg(12'h421, 64'h0, "R11 evt0 untouched");
        repeat (3) @(negedge clk);
        check("R2 all responses seen", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule